// File: doc/BRIEF.md
# Pixel Distance Score Stage with Slot Buffer

This stage turns one pixel's small row and column offsets into a distance score, one pixel per clock. The row offset and the column offset (each 0 to 2) are squared and summed into a squared distance. The iteration index (1 to 3) is squared and added to itself to form an upper bound. The score is that bound minus the squared distance, held as a 5-bit two's-complement number whose span is -6 to +12.

Each accepted sample stores its row offset, its column offset and its score into the next slot of a 30-slot register bank. A slot pointer picks the slot; it moves forward by one for each accepted sample and returns to slot 0 after slot 29. A synchronous clear sends the pointer back to slot 0. A separate read address returns any slot combinationally, so a stored entry can be read on the cycle after it is written. Neighbour maximum selection and iteration control are handled elsewhere.

The input is a valid/ready stream. `in_ready` is low only while `clr` is high. A sample is accepted on a rising edge where `in_valid` and `in_ready` are both high. There is no other back-pressure, because the bank overwrites its oldest slot instead of filling up. An upstream source that holds `in_valid` through a clear keeps its sample until the cycle after `clr` drops.

Top module: `edt_score_stage`

## Requirements
- R1: The squares of the row and column offsets are 0, 1 or 4 for offsets 0, 1 and 2. The square of the iteration index is 1, 4 or 9 for index values 1, 2 and 3.
- R2: The score equals (k + k*k) minus (r*r + c*c). The bound is formed in 4 bits. The score is stored as 5-bit two's complement and always lies between -6 and +12.
- R3: An accepted sample stores {r, c, score} in the slot given by `wr_ptr`. Reading that slot through `rd_addr` returns these values from the cycle after the accepting edge onward.
- R4: `wr_ptr` increases by one on each accepted sample. After slot 29 it returns to 0.
- R5: While `clr` is high, `wr_ptr` goes to 0 on the next edge and no slot is written, even with `in_valid` high. Clear wins over advance and leaves the stored data unchanged.
- R6: While `in_valid` is low, `wr_ptr` holds its value and every slot keeps its contents.
- R7: After reset, `wr_ptr` is 0 and every slot reads as all zeros. Read addresses 30 and 31 always return zeros.
- R8: `in_ready` is high exactly when `clr` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous pointer clear |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be taken (low during clear) |
| in_r | input | 2 | Row offset, 0 to 2 |
| in_c | input | 2 | Column offset, 0 to 2 |
| in_k | input | 2 | Iteration index, 1 to 3 |
| wr_ptr | output | 5 | Slot the next accepted sample goes to |
| rd_addr | input | 5 | Slot to read |
| rd_r | output | 2 | Stored row offset |
| rd_c | output | 2 | Stored column offset |
| rd_delta | output | 5 | Stored score, two's complement |

## Verification
The bench targets the most negative score (-6, from k=1 with both offsets at 2) and the largest score (+12). A design that drops the sign bit or squares in too few bits would return a large positive number or a wrapped value for these. It fills all 30 slots, then writes once more to check that the pointer wraps to slot 0 and overwrites only that slot. An off-by-one wrap would skip a slot or write past slot 29. It also raises `clr` while `in_valid` is high. A design that let the advance win, or wrote during the clear, would move the pointer to slot 2 or corrupt slot 1.

// File: rtl/edt_score_pkg.sv
package edt_score_pkg;
  parameter int OPW   = 2;
  parameter int SQW   = 4;
  parameter int DW    = 5;
  parameter int DEPTH = 30;
  parameter int AW    = $clog2(DEPTH);

  typedef struct packed {
    logic [OPW-1:0] r;
    logic [OPW-1:0] c;
    logic [DW-1:0]  delta;
  } slot_t;
endpackage

// File: rtl/edt_score_calc.sv
module edt_score_calc
  import edt_score_pkg::*;
(
  input  logic [OPW-1:0] r,
  input  logic [OPW-1:0] c,
  input  logic [OPW-1:0] k,
  output logic [DW-1:0]  delta
);
  localparam int PADW = SQW - OPW;

  logic [SQW-1:0] r_ext, c_ext, k_ext;
  logic [SQW-1:0] r_sq, c_sq, k_sq;
  logic [SQW-1:0] bound, dist_sq;

  always_comb begin
    r_ext   = {{PADW{1'b0}}, r};
    c_ext   = {{PADW{1'b0}}, c};
    k_ext   = {{PADW{1'b0}}, k};
    r_sq    = r_ext * r_ext;
    c_sq    = c_ext * c_ext;
    k_sq    = k_ext * k_ext;
    bound   = k_ext + k_sq;
    dist_sq = r_sq + c_sq;
    delta   = {1'b0, bound} - {1'b0, dist_sq};
  end

  // R2: with legal operands the score stays within -6..+12
  always_comb begin
    if (r <= 2'd2 && c <= 2'd2 && k != 2'd0) begin
      p_delta_span_r2: assert ($signed(delta) >= -6 && $signed(delta) <= 12);
    end
  end
endmodule

// File: rtl/edt_slot_counter.sv
module edt_slot_counter
  import edt_score_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ptr <= '0;
    else if (clr)          ptr <= '0;
    else if (adv)          ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr == LAST) |=> ptr == '0);
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);
  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr == '0);
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(ptr));
endmodule

// File: rtl/edt_slot_bank.sv
module edt_slot_bank
  import edt_score_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  slot_t         wd,
  input  logic [AW-1:0] ra,
  output slot_t         rd
);
  slot_t slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       slot_q[i] <= '0;
      else if (we && wa == AW'(i))      slot_q[i] <= wd;
    end

    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wa == AW'(i)) |=> slot_q[i] == $past(wd));
    p_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && wa == AW'(i)) |=> $stable(slot_q[i]));
  end

  always_comb begin
    rd = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ra == AW'(i)) rd = slot_q[i];
    end
  end
endmodule

// File: rtl/edt_score_stage.sv
module edt_score_stage
  import edt_score_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [1:0]     in_r,
  input  logic [1:0]     in_c,
  input  logic [1:0]     in_k,
  output logic [4:0]     wr_ptr,
  input  logic [4:0]     rd_addr,
  output logic [1:0]     rd_r,
  output logic [1:0]     rd_c,
  output logic [4:0]     rd_delta
);
  logic          accept;
  logic [DW-1:0] score;
  slot_t         wr_data, rd_data;

  assign in_ready = !clr;
  assign accept   = in_valid && in_ready;

  edt_score_calc u_calc (
    .r     (in_r),
    .c     (in_c),
    .k     (in_k),
    .delta (score)
  );

  assign wr_data = '{r: in_r, c: in_c, delta: score};

  edt_slot_counter u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .adv   (accept),
    .ptr   (wr_ptr)
  );

  edt_slot_bank u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (accept),
    .wa    (wr_ptr),
    .wd    (wr_data),
    .ra    (rd_addr),
    .rd    (rd_data)
  );

  assign rd_r     = rd_data.r;
  assign rd_c     = rd_data.c;
  assign rd_delta = rd_data.delta;

  // R5: no sample is taken while clear is high
  p_no_take_in_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && in_valid) |=> wr_ptr == '0);
endmodule

// File: tb/sim_edt_score_stage.sv
`timescale 1ns/1ps
module sim_edt_score_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_r = '0, in_c = '0, in_k = 2'd1;
  logic [4:0] wr_ptr, rd_addr = '0;
  logic [1:0] rd_r, rd_c;
  logic [4:0] rd_delta;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  edt_score_stage u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_ready(in_ready), .in_r(in_r), .in_c(in_c), .in_k(in_k),
    .wr_ptr(wr_ptr), .rd_addr(rd_addr), .rd_r(rd_r), .rd_c(rd_c),
    .rd_delta(rd_delta)
  );

  // {r, c, k, expected score as 5-bit two's complement}
  localparam int NV = 12;
  localparam logic [10:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'd1, 5'h02},
    {2'd1, 2'd0, 2'd1, 5'h01},
    {2'd1, 2'd1, 2'd1, 5'h00},
    {2'd2, 2'd2, 2'd1, 5'h1A},
    {2'd2, 2'd0, 2'd2, 5'h02},
    {2'd2, 2'd1, 2'd2, 5'h01},
    {2'd2, 2'd2, 2'd2, 5'h1E},
    {2'd0, 2'd0, 2'd3, 5'h0C},
    {2'd2, 2'd2, 2'd3, 5'h04},
    {2'd1, 2'd2, 2'd3, 5'h07},
    {2'd0, 2'd2, 2'd1, 5'h1E},
    {2'd1, 2'd1, 2'd3, 5'h0A}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic push(input logic [1:0] r, input logic [1:0] c, input logic [1:0] k);
    in_r = r; in_c = c; in_k = k; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic read_slot(input int a, input logic [1:0] er, input logic [1:0] ec,
                           input logic [4:0] ed, input string tag);
    rd_addr = 5'(a);
    #0.5;
    check(rd_r == er && rd_c == ec && rd_delta == ed, tag,
          {rd_r, rd_c, rd_delta}, {er, ec, ed});
  endtask

  initial begin
    #(4ns * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: reset state
    check(wr_ptr == 5'd0, "R7 ptr after reset", wr_ptr, 0);
    read_slot(0, 2'd0, 2'd0, 5'd0, "R7 slot0 zero");
    read_slot(29, 2'd0, 2'd0, 5'd0, "R7 slot29 zero");
    check(in_ready == 1'b1, "R8 ready with clr low", in_ready, 1);

    // R1 R2 R3 R4: table walk
    for (int i = 0; i < NV; i++) begin
      push(VEC[i][10:9], VEC[i][8:7], VEC[i][6:5]);
      check(wr_ptr == 5'(i + 1), "R4 ptr step", wr_ptr, i + 1);
      read_slot(i, VEC[i][10:9], VEC[i][8:7], VEC[i][4:0], "R2 R3 score stored");
    end
    for (int i = 0; i < NV; i++)
      read_slot(i, VEC[i][10:9], VEC[i][8:7], VEC[i][4:0], "R1 readback");

    // R6: idle cycles
    repeat (4) @(negedge clk);
    check(wr_ptr == 5'd12, "R6 ptr holds", wr_ptr, 12);
    read_slot(12, 2'd0, 2'd0, 5'd0, "R6 slot12 untouched");

    // R4: fill up to the wrap
    for (int i = NV; i < 30; i++) push(2'd0, 2'd1, 2'd2);
    check(wr_ptr == 5'd0, "R4 wrap to 0", wr_ptr, 0);
    read_slot(29, 2'd0, 2'd1, 5'h05, "R4 slot29 written");
    push(2'd2, 2'd2, 2'd3);
    check(wr_ptr == 5'd1, "R4 after wrap", wr_ptr, 1);
    read_slot(0, 2'd2, 2'd2, 5'h04, "R4 slot0 overwritten");
    read_slot(1, 2'd1, 2'd0, 5'h01, "R4 slot1 kept");

    // R5 R8: clear with valid high
    clr = 1'b1; in_r = 2'd0; in_c = 2'd1; in_k = 2'd3; in_valid = 1'b1;
    #0.5;
    check(in_ready == 1'b0, "R8 ready low in clear", in_ready, 0);
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    check(wr_ptr == 5'd0, "R5 clear wins", wr_ptr, 0);
    read_slot(1, 2'd1, 2'd0, 5'h01, "R5 slot1 not written");
    read_slot(0, 2'd2, 2'd2, 5'h04, "R5 data kept");

    // R7: out-of-range reads
    read_slot(30, 2'd0, 2'd0, 5'd0, "R7 addr30 zero");
    read_slot(31, 2'd0, 2'd0, 5'd0, "R7 addr31 zero");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule